// File: doc/BRIEF.md
# Converter Static Self-Test Sequencer

This block is the digital controller for an on-chip static self-test of an N-bit digital-to-analog converter. It needs no reference converter of higher resolution. While its test request is held high it walks through a fixed series of phases:

1. a check of the analog test path itself;
2. an autozero cycle that nulls the amplifier offset against ground;
3. an offset measurement at the lowest code;
4. a gain measurement at the highest code;
5. a differential-linearity sweep over every input code;
6. an integral-linearity check at seven critical codes.

In each phase the sequencer drives the converter code, the analog multiplexer select, the autozero enable and the bound selector. After a programmable settle time it samples a single comparator bit. Every error is tested against the upper half-LSB bound first and then against the lower one, and both tests must pass. The first failing comparison ends the run. The result (pass or fail, plus the phase and the code of the failure) stays on the outputs until the request is withdrawn. Withdrawing the request at any point returns every output to its safe idle value.

Top module: `dac_bist_seq`

## Requirements
- R1: While test_i is low, the block stays idle with busy_o, done_o, fail_o, az_o, bound_sel_o, code_o, fail_phase_o and fail_code_o all at zero and mux_sel_o at 0 (ground).
- R2: The first busy phase is the test-path check, with mux_sel_o = 1 (calibration reference) and code_o = 0. It holds two comparisons.
- R3: The autozero cycle follows the path check. az_o is 1 only during it, mux_sel_o is 0 (ground) throughout, and it lasts settle_i+1 cycles.
- R4: Offset is measured at code_o = 0 and gain at code_o = all ones, both with mux_sel_o = 2 (converter output).
- R5: The differential-linearity sweep uses mux_sel_o = 3 (step difference) and visits every code from 0 to 2^N-1 in ascending order.
- R6: Integral linearity is checked only at the seven codes k·2^(N-3) for k = 1..7, in ascending order, with mux_sel_o = 2.
- R7: Each measurement makes two comparisons at an unchanged code and select: first with bound_sel_o = 0 (+1/2 LSB), then with bound_sel_o = 1 (-1/2 LSB). cmp_i = 1 means the comparison passed.
- R8: Each comparison waits settle_i cycles after its outputs are applied, then samples cmp_i in the next cycle. One comparison therefore occupies settle_i+1 cycles.
- R9: On the first comparison with cmp_i = 0, the block stops and raises done_o with fail_o = 1. It latches fail_phase_o (1 path check, 3 offset, 4 gain, 5 differential sweep, 6 integral check) and fail_code_o, the code driven at that moment. No further codes are driven.
- R10: If every comparison passes, done_o rises with fail_o = 0 and stays high with the result stable while test_i remains high.
- R11: Dropping test_i at any time clears every output to its R1 value on the next clock edge. A later request restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_i | input | 1 | Self-test request, level sensitive |
| settle_i | input | SETTLE_W | Settle cycles before each sample |
| cmp_i | input | 1 | Comparator result, 1 = within bound |
| code_o | output | CODE_W | Code applied to the converter |
| az_o | output | 1 | Autozero enable |
| mux_sel_o | output | 2 | Analog multiplexer select: 0 ground, 1 calibration, 2 converter output, 3 step difference |
| bound_sel_o | output | 1 | 0 = +1/2 LSB bound, 1 = -1/2 LSB bound |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished |
| fail_o | output | 1 | Test failed, valid with done_o |
| fail_phase_o | output | 3 | Phase of the failing comparison |
| fail_code_o | output | CODE_W | Code of the failing comparison |

## Verification
A wrong phase, index or bound register in this block shows up at once on code_o, mux_sel_o or bound_sel_o. The bench tracks those outputs cycle by cycle. It flags a skipped or repeated sweep code, an integral check off the critical grid, or a lower-bound comparison that does not follow an upper one at the same code. A miscounted settle timer stretches or shortens the path-check and autozero windows, and those cycle counts are compared exactly on every run. A fault placed at one phase, code and bound by the comparator model must come back on the latched outputs as exactly that phase and code, as soon as done_o rises.

// File: rtl/dac_bist_pkg.sv
package dac_bist_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SELF = 3'd1,
    PH_AZ   = 3'd2,
    PH_OFFS = 3'd3,
    PH_GAIN = 3'd4,
    PH_DNL  = 3'd5,
    PH_INL  = 3'd6,
    PH_DONE = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    MX_GND  = 2'd0,
    MX_CAL  = 2'd1,
    MX_ABS  = 2'd2,
    MX_STEP = 2'd3
  } mux_e;

  localparam int unsigned NUM_CRIT = 7;
endpackage

// File: rtl/bist_settle_timer.sv
module bist_settle_timer #(
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (load_i)          cnt_q <= settle_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - SETTLE_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R8: a load arms the full settle window
  assert_settle_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_q == $past(settle_i)));

  // R8: the window counts down by one per cycle
  assert_settle_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - SETTLE_W'(1)));
endmodule

// File: rtl/bist_result_reg.sv
module bist_result_reg #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fail_set_i,
  input  logic              pass_set_i,
  input  logic [2:0]        phase_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fail_o,
  output logic [2:0]        phase_o,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o  <= 1'b0;
      phase_o <= '0;
      code_o  <= '0;
    end else if (clr_i) begin
      fail_o  <= 1'b0;
      phase_o <= '0;
      code_o  <= '0;
    end else if (fail_set_i && !fail_o) begin
      fail_o  <= 1'b1;
      phase_o <= phase_i;
      code_o  <= code_i;
    end
  end

  assert_set_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fail_set_i && pass_set_i));

  // R9: first failure is kept
  assert_first_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clr_i) |=> (fail_o && $stable(phase_o) && $stable(code_o)));
endmodule

// File: rtl/dac_bist_seq.sv
module dac_bist_seq
  import dac_bist_pkg::*;
#(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                test_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                cmp_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                az_o,
  output logic [1:0]          mux_sel_o,
  output logic                bound_sel_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic [2:0]          fail_phase_o,
  output logic [CODE_W-1:0]   fail_code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam int unsigned       CRIT_SH  = CODE_W - 3;
  localparam logic [CODE_W-1:0] CRIT_LAST = CODE_W'(NUM_CRIT - 1);

  phase_e            phase_q, phase_d;
  logic              bound_q, bound_d;
  logic [CODE_W-1:0] idx_q, idx_d;
  logic              load, expired, fail_set, pass_set, meas, sample;
  logic [CODE_W-1:0] crit_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bound_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bound_q <= bound_d;
      idx_q   <= idx_d;
    end
  end

  assign meas   = (phase_q == PH_SELF) || (phase_q == PH_OFFS) || (phase_q == PH_GAIN) ||
                  (phase_q == PH_DNL)  || (phase_q == PH_INL);
  assign sample = meas && expired;

  always_comb begin
    phase_d  = phase_q;
    bound_d  = bound_q;
    idx_d    = idx_q;
    load     = 1'b0;
    fail_set = 1'b0;
    pass_set = 1'b0;
    if (!test_i) begin
      phase_d = PH_IDLE;
      bound_d = 1'b0;
      idx_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_SELF;
          load    = 1'b1;
        end
        PH_AZ: if (expired) begin
          phase_d = PH_OFFS;
          load    = 1'b1;
        end
        PH_DONE: ;
        default: if (sample) begin
          if (!cmp_i) begin
            phase_d  = PH_DONE;
            fail_set = 1'b1;
          end else if (!bound_q) begin
            bound_d = 1'b1;
            load    = 1'b1;
          end else begin
            bound_d = 1'b0;
            load    = 1'b1;
            unique case (phase_q)
              PH_SELF: phase_d = PH_AZ;
              PH_OFFS: phase_d = PH_GAIN;
              PH_GAIN: begin
                phase_d = PH_DNL;
                idx_d   = '0;
              end
              PH_DNL: begin
                if (idx_q == CODE_MAX) begin
                  phase_d = PH_INL;
                  idx_d   = '0;
                end else begin
                  idx_d = idx_q + CODE_W'(1);
                end
              end
              default: begin
                if (idx_q == CRIT_LAST) begin
                  phase_d  = PH_DONE;
                  pass_set = 1'b1;
                  load     = 1'b0;
                end else begin
                  idx_d = idx_q + CODE_W'(1);
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  // critical codes: (idx+1) in the top three bits, lower bits zero
  assign crit_code = CODE_W'(idx_q[2:0] + 3'd1) << CRIT_SH;

  always_comb begin
    code_o    = '0;
    mux_sel_o = MX_GND;
    unique case (phase_q)
      PH_SELF: mux_sel_o = MX_CAL;
      PH_OFFS: mux_sel_o = MX_ABS;
      PH_GAIN: begin
        mux_sel_o = MX_ABS;
        code_o    = CODE_MAX;
      end
      PH_DNL: begin
        mux_sel_o = MX_STEP;
        code_o    = idx_q;
      end
      PH_INL: begin
        mux_sel_o = MX_ABS;
        code_o    = crit_code;
      end
      default: ;
    endcase
  end

  assign az_o        = (phase_q == PH_AZ);
  assign bound_sel_o = meas && bound_q;
  assign busy_o      = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign done_o      = (phase_q == PH_DONE);

  bist_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!test_i),
    .load_i    (load),
    .settle_i  (settle_i),
    .expired_o (expired)
  );

  bist_result_reg #(.CODE_W(CODE_W)) u_result (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!test_i),
    .fail_set_i (fail_set),
    .pass_set_i (pass_set),
    .phase_i    (phase_q),
    .code_i     (code_o),
    .fail_o     (fail_o),
    .phase_o    (fail_phase_o),
    .code_o     (fail_code_o)
  );

  assert_az_ground_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    az_o |-> (mux_sel_o == MX_GND && !busy_o == 1'b0));

  assert_abort_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> (!busy_o && !done_o && !fail_o && !az_o && code_o == '0 && fail_code_o == '0));

  assert_bound_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bound_sel_o) |-> ($stable(code_o) && $stable(mux_sel_o)));

  assert_fail_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && test_i) |=> (done_o && $stable(fail_o)));

  assert_start_self_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mux_sel_o == MX_CAL && code_o == '0));
endmodule

// File: tb/dac_bist_seq_test.sv
module dac_bist_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int SW = 4;
  localparam int NCODES = 1 << N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test = 1'b0;
  logic [SW-1:0] settle = '0;
  logic          cmp;
  logic [N-1:0]  code, fcode_o;
  logic          az, bnd, busy, done, fail;
  logic [1:0]    mux;
  logic [2:0]    fphase;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bist_seq #(.CODE_W(N), .SETTLE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .test_i(test), .settle_i(settle), .cmp_i(cmp),
    .code_o(code), .az_o(az), .mux_sel_o(mux), .bound_sel_o(bnd), .busy_o(busy),
    .done_o(done), .fail_o(fail), .fail_phase_o(fphase), .fail_code_o(fcode_o)
  );

  // behavioural comparator: a single injected failing point
  logic         f_en = 1'b0;
  logic [1:0]   f_mux = '0;
  logic [N-1:0] f_code = '0;
  logic         f_bnd = 1'b0;
  assign cmp = !(f_en && mux == f_mux && code == f_code && bnd == f_bnd);

  typedef struct packed { logic fail; logic [2:0] ph; logic [N-1:0] code; } result_t;
  result_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-run observation
  int az_cyc, az_bad, cal_cyc, dnl_max, order_bad, inl_bad, abs_lo, abs_hi;
  int first_mux;
  logic [NCODES-1:0] dnl_pos, dnl_neg, inl_seen;
  logic prev_done = 1'b0, prev_busy = 1'b0, prev_bnd = 1'b0;
  logic [N-1:0] prev_code = '0;
  logic [1:0]   prev_mux = '0;

  task automatic clear_stats();
    az_cyc = 0; az_bad = 0; cal_cyc = 0; dnl_max = -1; order_bad = 0; inl_bad = 0;
    abs_lo = 0; abs_hi = 0; first_mux = -1;
    dnl_pos = '0; dnl_neg = '0; inl_seen = '0;
  endtask

  // monitor: scoreboard pop on done, and output tracking
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !prev_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9/R10 unexpected done", 1, 0);
        end else begin
          result_t e;
          e = exp_q.pop_front();
          chk(fail == e.fail, e.fail ? "R9 fail flag" : "R10 pass flag", fail, e.fail);
          chk(fphase == e.ph, "R9 fail phase", fphase, e.ph);
          chk(fcode_o == e.code, "R9 fail code", fcode_o, e.code);
        end
      end
      if (az) begin
        az_cyc++;
        if (mux != 2'd0 || busy != 1'b1) az_bad++;
      end
      if (busy && !prev_busy) first_mux = mux;
      if (busy && mux == 2'd1) cal_cyc++;
      if (busy && mux == 2'd3) begin
        if (!bnd) dnl_pos[code] = 1'b1; else dnl_neg[code] = 1'b1;
        if (int'(code) > dnl_max) dnl_max = int'(code);
      end
      if (busy && mux == 2'd2) begin
        if (code == '0) abs_lo++;
        else if (code == '1) abs_hi++;
        else begin
          inl_seen[code] = 1'b1;
          if (code[N-4:0] != '0) inl_bad++;
        end
      end
      if (busy && bnd && !prev_bnd && (code != prev_code || mux != prev_mux)) order_bad++;
      if (busy && bnd && !prev_bnd && !prev_busy) order_bad++;
      prev_done <= done;
      prev_busy <= busy;
      prev_bnd  <= bnd;
      prev_code <= code;
      prev_mux  <= mux;
    end
  end

  task automatic check_idle(input string tag);
    chk(!busy && !done && !fail && !az && !bnd && code == '0 && mux == 2'd0 &&
        fphase == '0 && fcode_o == '0, tag,
        {busy, done, fail, az, bnd}, 0);
  endtask

  task automatic run_case(input logic en, input logic [1:0] fm, input logic [N-1:0] fc,
                          input logic fb, input logic [SW-1:0] st, input result_t e);
    int guard;
    clear_stats();
    f_en = en; f_mux = fm; f_code = fc; f_bnd = fb; settle = st;
    exp_q.push_back(e);
    @(negedge clk);
    test = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done && guard < 20000);
    chk(done, "R10 done reached", done, 1);
    @(negedge clk);
    chk(done && fail == e.fail, "R10 result held", {done, fail}, {1'b1, e.fail});
  endtask

  task automatic finish_case();
    test = 1'b0;
    @(negedge clk);
    check_idle("R11 cleared after test drop");
    f_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle without request");

    // full pass, settle 3
    run_case(1'b0, 2'd0, '0, 1'b0, 4'd3, '{fail: 1'b0, ph: 3'd0, code: '0});
    chk(first_mux == 1, "R2 first phase selects calibration", first_mux, 1);
    chk(cal_cyc == 8, "R2/R8 path check cycles", cal_cyc, 8);
    chk(az_cyc == 4 && az_bad == 0, "R3 autozero window on ground", az_cyc, 4);
    chk(abs_lo >= 1 && abs_hi >= 1, "R4 offset and gain codes", abs_lo, 1);
    chk(dnl_pos == '1 && dnl_neg == '1, "R5 sweep covers every code", $countones(dnl_neg), NCODES);
    chk($countones(inl_seen) == 7 && inl_bad == 0, "R6 seven critical codes", $countones(inl_seen), 7);
    chk(order_bad == 0, "R7 upper then lower bound", order_bad, 0);
    finish_case();

    // full pass, settle 0
    run_case(1'b0, 2'd0, '0, 1'b0, 4'd0, '{fail: 1'b0, ph: 3'd0, code: '0});
    chk(cal_cyc == 2, "R8 zero settle path check", cal_cyc, 2);
    chk(az_cyc == 1, "R3/R8 zero settle autozero", az_cyc, 1);
    finish_case();

    // failures at each phase
    run_case(1'b1, 2'd1, '0, 1'b1, 4'd2, '{fail: 1'b1, ph: 3'd1, code: '0});
    chk(az_cyc == 0, "R9 stop before autozero", az_cyc, 0);
    finish_case();
    run_case(1'b1, 2'd2, '0, 1'b0, 4'd1, '{fail: 1'b1, ph: 3'd3, code: '0});
    chk(abs_hi == 0, "R9 gain not reached after offset fail", abs_hi, 0);
    finish_case();
    run_case(1'b1, 2'd2, '1, 1'b1, 4'd1, '{fail: 1'b1, ph: 3'd4, code: '1});
    finish_case();
    run_case(1'b1, 2'd3, 6'd37, 1'b1, 4'd1, '{fail: 1'b1, ph: 3'd5, code: 6'd37});
    chk(dnl_max == 37, "R9 sweep stops at failing code", dnl_max, 37);
    finish_case();
    run_case(1'b1, 2'd3, 6'd63, 1'b0, 4'd0, '{fail: 1'b1, ph: 3'd5, code: 6'd63});
    chk($countones(inl_seen) == 0, "R9 no integral check after sweep fail", $countones(inl_seen), 0);
    finish_case();
    run_case(1'b1, 2'd2, 6'd24, 1'b1, 4'd2, '{fail: 1'b1, ph: 3'd6, code: 6'd24});
    chk($countones(inl_seen) == 3, "R6 critical codes up to failure", $countones(inl_seen), 3);
    finish_case();

    // abort mid-sweep
    clear_stats();
    settle = 4'd1;
    @(negedge clk);
    test = 1'b1;
    while (!(mux == 2'd3 && code == 6'd10)) @(negedge clk);
    test = 1'b0;
    @(negedge clk);
    check_idle("R11 abort clears outputs");
    repeat (3) @(negedge clk);
    check_idle("R1 stays idle after abort");

    // restart after abort
    run_case(1'b0, 2'd0, '0, 1'b0, 4'd1, '{fail: 1'b0, ph: 3'd0, code: '0});
    chk(first_mux == 1 && cal_cyc == 4, "R11 restart from path check", cal_cyc, 4);
    finish_case();

    chk(exp_q.size() == 0, "R9/R10 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule